// File: doc/BRIEF.md
# Audio Bit-Clock Prescaler

This block produces the bit clock for the master side of an audio serial port. It divides its input clock by a ratio set in a 16-bit configuration word. The word holds an 8-bit linear divide value, an odd-ratio bit and a master-clock output enable. The resulting ratio is twice the linear value, plus one when the odd bit is set. Odd ratios therefore come out with a high phase one input cycle longer than the low phase.

The divider runs only while the port is enabled and in master mode. While it is stopped, the bit clock is held low and the phase counter is cleared. The configuration can be written only while the port is disabled. The active settings are frozen at the moment the divider starts.

A one-cycle strobe marks every falling edge of the bit clock, so that shift logic can stay in the input clock domain. A master-clock output-enable level is provided so that the pad driver can forward the input clock. Divide values of zero and one are not allowed. They are replaced by two, and a sticky error flag is raised.

Top module: `aclk_prescaler`

## Requirements
- R1: After reset the configuration reads 0x0002, and the error flag, bit clock, strobe and master-clock enable are all 0.
- R2: With the odd bit (bit 8) clear and linear value N (bits 7:0), the bit clock has period 2N input cycles, with N cycles high and N cycles low.
- R3: With the odd bit set, the bit clock has period 2N+1 input cycles, with N+1 cycles high and N cycles low.
- R4: While not running, the bit clock is low. After the divider starts, it first goes high once N rising input edges have been seen with the divider running.
- R5: The falling-edge strobe is high for exactly one input cycle, in the cycle in which the bit clock has just gone from high to low, and at no other time.
- R6: A written linear value of 0 or 1 is stored and used as 2, and the configuration-error flag is set. The flag then stays set until reset.
- R7: A configuration write made while the enable input is high is ignored. The read-back value and the running waveform are unchanged.
- R8: Bits 15:10 of the configuration always read as zero, whatever was written to them.
- R9: The master-clock output enable is high only while the divider runs and bit 9 of the latched configuration is set.
- R10: With the enable input high but master mode low, the divider does not run: the bit clock stays low, and the strobe and master-clock enable stay at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock to be divided |
| rst_i | input | 1 | Synchronous active-high reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 16 | Configuration write data |
| cfg_rdata_o | output | 16 | Configuration read-back |
| en_i | input | 1 | Port enable |
| master_i | input | 1 | Master mode select |
| bclk_o | output | 1 | Divided bit clock |
| fall_stb_o | output | 1 | One-cycle strobe on each bit-clock falling edge |
| mclk_oe_o | output | 1 | Master-clock output enable for the pad |
| cfg_err_o | output | 1 | Sticky flag for a forbidden divide value |

## Verification
The hardest case to reach is a write that lands while the divider is already running. It must leave both the read-back and the waveform untouched, and that can only be seen by comparing every cycle against the arithmetic expectation. The bench sweeps linear values 2 to 12 with both odd settings, plus the maximum value. In each case it injects a stray write a few cycles after start. It then checks every sampled cycle of the bit clock and strobe against the phase computed from the cycle count since enable. Forbidden values are tested last, so that the sticky flag does not mask the earlier reset check.

// File: rtl/aclk_div_pkg.sv
package aclk_div_pkg;

    localparam int DIV_W     = 8;
    localparam int REG_W     = 16;
    localparam int CNT_W     = DIV_W + 1;
    localparam int DIV_MIN   = 2;
    localparam int PAD_W     = REG_W - DIV_W - 2;

    typedef struct packed {
        logic             mcke;
        logic             odd;
        logic [DIV_W-1:0] div;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{mcke: 1'b0, odd: 1'b0, div: DIV_W'(DIV_MIN)};

    function automatic cfg_t cfg_unpack(input logic [REG_W-1:0] w);
        cfg_t c;
        c.div  = w[DIV_W-1:0];
        c.odd  = w[DIV_W];
        c.mcke = w[DIV_W+1];
        return c;
    endfunction

    function automatic logic div_forbidden(input logic [DIV_W-1:0] d);
        return d < DIV_W'(DIV_MIN);
    endfunction

    function automatic cfg_t cfg_sanitize(input cfg_t c);
        cfg_t s;
        s = c;
        if (div_forbidden(c.div)) s.div = DIV_W'(DIV_MIN);
        return s;
    endfunction

    function automatic logic [REG_W-1:0] cfg_pack(input cfg_t c);
        return {{PAD_W{1'b0}}, c};
    endfunction

endpackage

// File: rtl/aclk_cfg_reg.sv
module aclk_cfg_reg
    import aclk_div_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             we_i,
    input  logic [REG_W-1:0] wdata_i,
    input  logic             en_i,
    input  logic             run_i,
    output cfg_t             cfg_o,
    output cfg_t             act_o,
    output logic             err_o
);

    cfg_t cfg_q, cfg_d, act_q;
    logic err_q, wr_ok;
    cfg_t wr_cfg;

    assign wr_ok  = we_i && !en_i;
    assign wr_cfg = cfg_unpack(wdata_i);

    always_comb begin
        cfg_d = cfg_q;
        if (wr_ok) cfg_d = cfg_sanitize(wr_cfg);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cfg_q <= CFG_RESET;
            act_q <= CFG_RESET;
            err_q <= 1'b0;
        end else begin
            cfg_q <= cfg_d;
            if (!run_i) act_q <= cfg_d;
            if (wr_ok && div_forbidden(wr_cfg.div)) err_q <= 1'b1;
        end
    end

    assign cfg_o = cfg_q;
    assign act_o = act_q;
    assign err_o = err_q;

    // R7: writes while enabled leave the register untouched
    p_wr_ignored_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        en_i |=> $stable(cfg_q));
    // R6: error flag is sticky
    p_err_sticky_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        err_q |=> err_q);
    // R6: stored divide value is never a forbidden one
    p_div_legal_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        cfg_q.div >= DIV_W'(DIV_MIN) && act_q.div >= DIV_W'(DIV_MIN));
    // R7: latched settings hold while running
    p_act_hold_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        run_i |=> $stable(act_q));

endmodule

// File: rtl/aclk_div_core.sv
module aclk_div_core
    import aclk_div_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic run_i,
    input  cfg_t act_i,
    output logic bclk_o,
    output logic fall_stb_o
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] half_len;
    logic             bclk_q, stb_q, at_end;

    // high phase carries the extra cycle of an odd ratio
    assign half_len = {1'b0, act_i.div} + CNT_W'(bclk_q & act_i.odd);
    assign at_end   = (cnt_q == half_len - CNT_W'(1));

    always_ff @(posedge clk_i) begin
        if (rst_i || !run_i) begin
            cnt_q  <= '0;
            bclk_q <= 1'b0;
            stb_q  <= 1'b0;
        end else if (at_end) begin
            cnt_q  <= '0;
            bclk_q <= !bclk_q;
            stb_q  <= bclk_q;
        end else begin
            cnt_q  <= cnt_q + CNT_W'(1);
            stb_q  <= 1'b0;
        end
    end

    assign bclk_o     = bclk_q;
    assign fall_stb_o = stb_q;

    // R4: output low whenever the divider was stopped
    p_idle_low_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        !run_i |=> !bclk_q);
    // R5: strobe lasts one cycle
    p_stb_single_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        stb_q |=> !stb_q);
    // R5: strobe coincides with a high-to-low transition
    p_stb_edge_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        stb_q |-> (!bclk_q && $past(bclk_q)));
    // R2: counter never passes the phase length
    p_cnt_bound_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        cnt_q < half_len);

endmodule

// File: rtl/aclk_prescaler.sv
module aclk_prescaler
    import aclk_div_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_i,
    input  logic        cfg_we_i,
    input  logic [15:0] cfg_wdata_i,
    output logic [15:0] cfg_rdata_o,
    input  logic        en_i,
    input  logic        master_i,
    output logic        bclk_o,
    output logic        fall_stb_o,
    output logic        mclk_oe_o,
    output logic        cfg_err_o
);

    logic run;
    cfg_t cfg, act;

    assign run = en_i && master_i;

    aclk_cfg_reg u_cfg (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .we_i   (cfg_we_i),
        .wdata_i(cfg_wdata_i),
        .en_i   (en_i),
        .run_i  (run),
        .cfg_o  (cfg),
        .act_o  (act),
        .err_o  (cfg_err_o)
    );

    aclk_div_core u_core (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .run_i     (run),
        .act_i     (act),
        .bclk_o    (bclk_o),
        .fall_stb_o(fall_stb_o)
    );

    assign cfg_rdata_o = cfg_pack(cfg);
    assign mclk_oe_o   = run && act.mcke;

    // R10: nothing toggles outside master mode
    p_no_run_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        !master_i |=> (!bclk_o && !fall_stb_o));
    // R9: pad enable only while running
    p_mclk_run_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        mclk_oe_o |-> run);

endmodule

// File: tb/aclk_prescaler_bench.sv
module aclk_prescaler_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        we;
    logic [15:0] wdata;
    logic [15:0] rdata;
    logic        en, master;
    logic        bclk, stb, mclk_oe, err;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = !clk;

    aclk_prescaler u_aclk_prescaler (
        .clk_i      (clk),
        .rst_i      (rst),
        .cfg_we_i   (we),
        .cfg_wdata_i(wdata),
        .cfg_rdata_o(rdata),
        .en_i       (en),
        .master_i   (master),
        .bclk_o     (bclk),
        .fall_stb_o (stb),
        .mclk_oe_o  (mclk_oe),
        .cfg_err_o  (err)
    );

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [15:0] v);
        @(negedge clk);
        we = 1'b1; wdata = v;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic run_case(input int n, input bit odd, input bit mck);
        logic [15:0] v;
        int per, wave_bad, stb_bad, mck_bad, q;
        bit eb, es;
        v = {6'b0, mck, odd, 8'(n)};
        write_cfg(v);
        check("R8 readback", int'(rdata), int'(v));
        per = 2 * n + int'(odd);
        wave_bad = 0; stb_bad = 0; mck_bad = 0;
        en = 1'b1; master = 1'b1;
        for (int k = 1; k <= 2 * per + n + 2; k++) begin
            if (k == 3) begin we = 1'b1; wdata = 16'h0107; end
            @(negedge clk);
            we = 1'b0;
            if (k < n) begin
                eb = 1'b0; es = 1'b0;
            end else begin
                q  = (k - n) % per;
                eb = (q < n + int'(odd));
                es = (q == n + int'(odd));
            end
            if (bclk !== eb) wave_bad++;
            if (stb !== es)  stb_bad++;
            if (mclk_oe !== mck) mck_bad++;
        end
        check(odd ? "R3 odd waveform" : "R2 even waveform", wave_bad, 0);
        check("R5 strobe", stb_bad, 0);
        check("R9 mclk enable", mck_bad, 0);
        check("R7 write ignored", int'(rdata), int'(v));
        @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        check("R4 idle low", int'({bclk, stb, mclk_oe}), 0);
    endtask

    initial begin
        int bad;
        rst = 1'b1; we = 1'b0; wdata = '0; en = 1'b0; master = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset cfg", int'(rdata), 16'h0002);
        check("R1 reset outputs", int'({err, bclk, stb, mclk_oe}), 0);

        for (int n = 2; n <= 12; n++) begin
            for (int o = 0; o < 2; o++) run_case(n, o[0], n[0] ^ o[0]);
        end
        run_case(255, 1'b1, 1'b1);

        // R10: enabled but not master
        write_cfg(16'h0203);
        en = 1'b1; master = 1'b0;
        bad = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (bclk || stb || mclk_oe) bad++;
        end
        check("R10 slave idle", bad, 0);
        en = 1'b0;

        // R8: reserved bits read zero
        write_cfg(16'hFC05);
        check("R8 reserved zero", int'(rdata), 16'h0005);
        check("R6 no error yet", int'(err), 0);

        // R6: forbidden values
        write_cfg(16'h0101);
        check("R6 clamp one", int'(rdata), 16'h0102);
        check("R6 flag set", int'(err), 1);
        write_cfg(16'h0005);
        check("R6 flag sticky", int'(err), 1);
        write_cfg(16'h0000);
        check("R6 clamp zero", int'(rdata), 16'h0002);
        run_case(2, 1'b0, 1'b0);
        check("R6 flag still set", int'(err), 1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule